// File: doc/BRIEF.md
# Quad-Word Instruction Alignment Buffer

This block sits between an instruction fetch unit and the decode stages. Fetch hands over 128-bit quad words made of four 32-bit words, together with the word address of the quad's first word and one length tag per word. Decode wants whole instructions, and each instruction is one or two 32-bit words. The block holds the fetched words in a small circular store and hands out one instruction per handshake. An instruction may start in the last word of one quad and finish in the first word of the next, so the block reassembles such instructions across the quad boundary.

Fetch can run ahead of execution. When a branch redirects fetch, the words already held are stale. The flush input drops all of them in one cycle. Any quad offered in that same cycle is dropped as well, so the first quad accepted after the flush is the one from the new fetch target. Opcode length decoding is outside this block: the length tag arrives with each word, already decoded.

Top module: `iab_quad_align`

## Requirements
- R1: While reset is applied, and in the first cycle after reset is released, `i_valid_o` is 0 and `q_ready_o` is 1 (the store is empty).
- R2: When all four tags of an accepted quad are 0, the block emits four 32-bit instructions in word order (word i taken from `q_data_i[32*i+31:32*i]`). Each has `i_long_o` = 0, and the address of word i is `q_addr_i` + i.
- R3: When the tag of the word at the head of the store is 1, that word and the next one leave as one 64-bit instruction. The first word goes in `i_data_o[31:0]`, the second in `i_data_o[63:32]`, and `i_long_o` is 1. The address is that of the first word, and the read position then advances by two words.
- R4: A 64-bit instruction is presented only when both of its words are held. If its first word is the last word held, `i_valid_o` stays 0 until the next quad arrives, and the instruction then spans the two quads.
- R5: `q_ready_o` is 1 exactly when at least four of the eight word slots are free. A quad offered while `q_ready_o` is 0 is not taken, and the held word count never exceeds eight.
- R6: A cycle with `flush_i` = 1 empties the store, so `i_valid_o` is 0 in the next cycle. A quad offered in the same cycle is dropped, and no instruction is consumed in that cycle.
- R7: While `i_valid_o` = 1 and `i_ready_i` = 0 (and no flush), the presented data, length flag and address stay unchanged in the next cycle.
- R8: The tag of the second word of a 64-bit instruction is ignored: that word is payload only, and the next instruction starts after it.
- R9: For a 32-bit instruction, `i_data_o[63:32]` is 0.
- R10: Tag bit `q_long_i[i]` belongs to word i of the quad, so a 64-bit instruction may start at any word position inside a quad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Drop all held words and any quad offered this cycle |
| q_valid_i | input | 1 | Fetch offers a quad word |
| q_ready_o | output | 1 | At least four free word slots |
| q_addr_i | input | 30 | Word address of word 0 of the offered quad |
| q_data_i | input | 128 | Four 32-bit words, word i in bits 32*i+31:32*i |
| q_long_i | input | 4 | Per-word tag: 1 marks the start of a 64-bit instruction |
| i_valid_o | output | 1 | A complete instruction is presented |
| i_ready_i | input | 1 | Decode takes the presented instruction |
| i_data_o | output | 64 | Instruction, first word in the low half |
| i_long_o | output | 1 | 1 for a 64-bit instruction |
| i_addr_o | output | 30 | Word address of the instruction's first word |

## Verification
A wrong read position shows at the ports as soon as the next instruction is presented: the address no longer follows the words in sequence, or the halves of a 64-bit instruction come out swapped or shifted. A wrong word count shows within one cycle. Either `q_ready_o` flips at the wrong fill level, or a long instruction is presented before its second word has arrived. A flush that leaves state behind shows as a valid instruction, or an old address, in the cycle right after the flush. The bench keeps its own word queue and compares valid, ready, data, flag and address in every cycle, so each of these faults shows up on the first cycle it affects.

// File: rtl/iab_pkg.sv
package iab_pkg;
  parameter int WORD_W = 32;
  parameter int ADDR_W = 30;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              lng;
  } word_t;
endpackage

// File: rtl/iab_ctrl.sv
module iab_ctrl #(
  parameter int DEPTH = 8,
  parameter int QW    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop1,
  input  logic             pop2,
  input  logic             flush,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             in_ready
);
  logic [PTR_W-1:0] wr_n, rd_n;
  logic [CNT_W-1:0] cnt_n;
  logic [1:0]       step;

  always_comb begin
    step = pop2 ? 2'd2 : (pop1 ? 2'd1 : 2'd0);
    wr_n = wr_ptr;
    rd_n = rd_ptr;
    cnt_n = count;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      rd_n  = rd_ptr + PTR_W'(step);
      cnt_n = count - CNT_W'(step);
      if (push) begin
        wr_n  = wr_ptr + PTR_W'(QW);
        cnt_n = count - CNT_W'(step) + CNT_W'(QW);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      count  <= cnt_n;
    end
  end

  assign in_ready = (CNT_W'(DEPTH) - count) >= CNT_W'(QW);
endmodule

// File: rtl/iab_store.sv
module iab_store
  import iab_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int QW    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LSEL_W = (QW > 1) ? $clog2(QW) : 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [PTR_W-1:0]     wr_ptr,
  input  logic [QW*WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [QW-1:0]        wr_tag,
  input  logic [PTR_W-1:0]     rd_ptr,
  output word_t                head0,
  output logic [WORD_W-1:0]    head1_data
);
  word_t ent [DEPTH];
  word_t head1;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [PTR_W-1:0]  lane;
    logic [LSEL_W-1:0] lsel;
    logic              hit;
    word_t             slot_n;
    word_t             slot_q;

    always_comb begin
      lane = PTR_W'(k) - wr_ptr;
      lsel = lane[LSEL_W-1:0];
      hit  = we && (int'(lane) < QW);
      slot_n.data = wr_data[int'(lsel)*WORD_W +: WORD_W];
      slot_n.addr = wr_addr + ADDR_W'(lsel);
      slot_n.lng  = wr_tag[lsel];
    end

    always_ff @(posedge clk) begin
      if (hit) slot_q <= slot_n;
    end

    assign ent[k] = slot_q;
  end

  assign head0      = ent[rd_ptr];
  assign head1      = ent[rd_ptr + PTR_W'(1)];
  assign head1_data = head1.data;
endmodule

// File: rtl/iab_extract.sv
module iab_extract
  import iab_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  word_t               head0,
  input  logic [WORD_W-1:0]   head1_data,
  input  logic [CNT_W-1:0]    count,
  input  logic                out_ready,
  input  logic                flush,
  output logic                out_valid,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_long,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                pop1,
  output logic                pop2
);
  logic have1, have2, fire;

  always_comb begin
    have1     = count >= CNT_W'(1);
    have2     = count >= CNT_W'(2);
    out_valid = have1 && (!head0.lng || have2);
    out_long  = head0.lng;
    out_addr  = head0.addr;
    out_data  = head0.lng ? {head1_data, head0.data} : {{WORD_W{1'b0}}, head0.data};
    fire      = out_valid && out_ready && !flush;
    pop1      = fire && !head0.lng;
    pop2      = fire && head0.lng;
  end
endmodule

// File: rtl/iab_quad_align.sv
module iab_quad_align
  import iab_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int QW    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 q_valid_i,
  output logic                 q_ready_o,
  input  logic [ADDR_W-1:0]    q_addr_i,
  input  logic [QW*WORD_W-1:0] q_data_i,
  input  logic [QW-1:0]        q_long_i,
  output logic                 i_valid_o,
  input  logic                 i_ready_i,
  output logic [2*WORD_W-1:0]  i_data_o,
  output logic                 i_long_o,
  output logic [ADDR_W-1:0]    i_addr_o
);
  logic             rst_meta, rst_q;
  logic             push, pop1, pop2;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  word_t            head0;
  logic [WORD_W-1:0] head1_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign push = q_valid_i && q_ready_o && !flush_i;

  iab_ctrl #(.DEPTH(DEPTH), .QW(QW)) u_ctrl (
    .clk(clk), .rst_n(rst_q), .push(push), .pop1(pop1), .pop2(pop2),
    .flush(flush_i), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .in_ready(q_ready_o)
  );

  iab_store #(.DEPTH(DEPTH), .QW(QW)) u_store (
    .clk(clk), .we(push), .wr_ptr(wr_ptr), .wr_data(q_data_i),
    .wr_addr(q_addr_i), .wr_tag(q_long_i), .rd_ptr(rd_ptr),
    .head0(head0), .head1_data(head1_data)
  );

  iab_extract #(.DEPTH(DEPTH)) u_extract (
    .head0(head0), .head1_data(head1_data), .count(count),
    .out_ready(i_ready_i), .flush(flush_i), .out_valid(i_valid_o),
    .out_data(i_data_o), .out_long(i_long_o), .out_addr(i_addr_o),
    .pop1(pop1), .pop2(pop2)
  );
endmodule

// File: rtl/iab_quad_align_chk.sv
module iab_quad_align_chk
  import iab_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                q_valid,
  input logic                q_ready,
  input logic                i_valid,
  input logic                i_ready,
  input logic [2*WORD_W-1:0] i_data,
  input logic                i_long,
  input logic [ADDR_W-1:0]   i_addr,
  input logic [CNT_W-1:0]    count
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (!i_valid && q_ready));

  p_long_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_long) |-> count >= CNT_W'(2));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_fetch_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> count <= $past(count));

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !i_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_ready && !flush) |=>
      (i_valid && $stable(i_data) && $stable(i_long) && $stable(i_addr)));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_long) |-> i_data[2*WORD_W-1:WORD_W] == '0);
endmodule

bind iab_quad_align iab_quad_align_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_q), .flush(flush_i), .q_valid(q_valid_i),
  .q_ready(q_ready_o), .i_valid(i_valid_o), .i_ready(i_ready_i),
  .i_data(i_data_o), .i_long(i_long_o), .i_addr(i_addr_o), .count(count)
);

// File: tb/iab_quad_align_tb.sv
module iab_quad_align_tb;
  localparam int DEPTH = 8;

  logic         clk;
  logic         rst_n;
  logic         flush_i;
  logic         q_valid_i;
  logic         q_ready_o;
  logic [29:0]  q_addr_i;
  logic [127:0] q_data_i;
  logic [3:0]   q_long_i;
  logic         i_valid_o;
  logic         i_ready_i;
  logic [63:0]  i_data_o;
  logic         i_long_o;
  logic [29:0]  i_addr_o;

  int n_chk;
  int n_fail;
  string cur_req;
  logic [29:0] next_qa;

  logic [31:0] md[$];
  logic [29:0] ma[$];
  bit          mt[$];

  iab_quad_align u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .q_valid_i(q_valid_i),
    .q_ready_o(q_ready_o), .q_addr_i(q_addr_i), .q_data_i(q_data_i),
    .q_long_i(q_long_i), .i_valid_o(i_valid_o), .i_ready_i(i_ready_i),
    .i_data_o(i_data_o), .i_long_o(i_long_o), .i_addr_o(i_addr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_valid();
    if (md.size() == 0) return 1'b0;
    return !mt[0] || (md.size() >= 2);
  endfunction

  function automatic logic [63:0] exp_data();
    if (mt[0]) return {md[1], md[0]};
    return {32'h0, md[0]};
  endfunction

  function automatic bit exp_ready();
    return (DEPTH - md.size()) >= 4;
  endfunction

  // one cycle: drive at negedge, compare against the model, update the model
  task automatic step(bit v, logic [29:0] a, logic [127:0] d, logic [3:0] t,
                      bit ordy, bit fl, output bit took);
    bit ev;
    @(negedge clk);
    q_valid_i = v; q_addr_i = a; q_data_i = d; q_long_i = t;
    i_ready_i = ordy; flush_i = fl;
    ev = exp_valid();
    chk(q_ready_o === exp_ready(), cur_req, "q_ready", 64'(q_ready_o), 64'(exp_ready()));
    chk(i_valid_o === ev, cur_req, "i_valid", 64'(i_valid_o), 64'(ev));
    if (ev) begin
      chk(i_long_o === mt[0], cur_req, "i_long", 64'(i_long_o), 64'(mt[0]));
      chk(i_addr_o === ma[0], cur_req, "i_addr", 64'(i_addr_o), 64'(ma[0]));
      chk(i_data_o === exp_data(), cur_req, "i_data", i_data_o, exp_data());
      if (!mt[0]) chk(i_data_o[63:32] === 32'h0, "R9", "upper half", 64'(i_data_o[63:32]), 64'h0);
    end
    took = 1'b0;
    if (fl) begin
      md.delete(); ma.delete(); mt.delete();
    end else begin
      if (ev && ordy) begin
        int n = mt[0] ? 2 : 1;
        for (int k = 0; k < n; k++) begin
          void'(md.pop_front()); void'(ma.pop_front()); void'(mt.pop_front());
        end
      end
      if (v && q_ready_o) begin
        took = 1'b1;
        for (int k = 0; k < 4; k++) begin
          md.push_back(d[32*k +: 32]);
          ma.push_back(a + 30'(k));
          mt.push_back(t[k]);
        end
      end
    end
  endtask

  task automatic quad(logic [3:0] t, bit ordy);
    bit took;
    logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
    step(1'b1, next_qa, d, t, ordy, 1'b0, took);
    if (took) next_qa = next_qa + 30'd4;
  endtask

  task automatic idle(int n, bit ordy);
    bit took;
    for (int k = 0; k < n; k++) step(1'b0, 30'h0, 128'h0, 4'h0, ordy, 1'b0, took);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit took;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; flush_i = 1'b0; q_valid_i = 1'b0; q_addr_i = '0;
    q_data_i = '0; q_long_i = '0; i_ready_i = 1'b0;
    next_qa = 30'h100;

    cur_req = "R1";
    repeat (3) begin
      @(negedge clk);
      chk(i_valid_o === 1'b0, "R1", "i_valid in reset", 64'(i_valid_o), 64'h0);
      chk(q_ready_o === 1'b1, "R1", "q_ready in reset", 64'(q_ready_o), 64'h1);
    end
    rst_n = 1'b1;
    idle(4, 1'b1);

    cur_req = "R2";  quad(4'b0000, 1'b0); idle(6, 1'b1);
    cur_req = "R3";  quad(4'b0101, 1'b1); idle(4, 1'b1);
    cur_req = "R8";  quad(4'b0111, 1'b1); idle(4, 1'b1);
    cur_req = "R10"; quad(4'b0010, 1'b1); idle(5, 1'b1);
    cur_req = "R4";  quad(4'b1000, 1'b1); idle(6, 1'b1);
    quad(4'b0000, 1'b1); idle(6, 1'b1);
    cur_req = "R5";  quad(4'b0000, 1'b0); quad(4'b0000, 1'b0);
    quad(4'b0000, 1'b0); quad(4'b0000, 1'b0);
    chk(q_ready_o === 1'b0, "R5", "q_ready when full", 64'(q_ready_o), 64'h0);
    idle(10, 1'b1);
    cur_req = "R7";  quad(4'b0001, 1'b0); idle(4, 1'b0); idle(4, 1'b1);
    cur_req = "R6";  quad(4'b0000, 1'b0);
    step(1'b1, next_qa, {4{32'hDEAD_BEEF}}, 4'h0, 1'b1, 1'b1, took);
    next_qa = 30'h2000;
    idle(3, 1'b1);

    cur_req = "R9";
    for (int c = 0; c < 4000; c++) begin
      bit v = ($urandom % 4) != 0;
      bit o = ($urandom % 4) != 0;
      bit f = ($urandom % 64) == 0;
      logic [3:0] t = 4'($urandom);
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      step(v, next_qa, d, t, o, f, took);
      if (f) next_qa = 30'($urandom) & ~30'h3;
      else if (took) next_qa = next_qa + 30'd4;
    end
    idle(10, 1'b1);

    summary();
    $finish;
  end
endmodule